// File: doc/BRIEF.md
# Floating-Point Status Word with Compare Queue

This block keeps the 32-bit status word of a floating-point unit. Its low bits are controls that the datapath reads continuously: a two-bit rounding selection is decoded into a one-hot strobe vector, and a single bit enables flush-to-zero for both operands and results. Its high bits collect sticky exception flags. The arithmetic units report each completed operation together with a five-bit flag vector. The block ORs those flags into the word. When a freshly reported flag meets its enable bit in the word, it raises a one-cycle trap request.

Compare operations also report a two-bit relation code, a five-bit predicate mask and a four-bit target index. The predicate bit chosen by the relation becomes the compare result. A nonzero target writes that result into one directly addressed condition bit. A zero target pushes it into a condition bit that feeds a ten-deep shift queue of earlier results. Software may overwrite the whole word at any time, and such a write wins over any update in the same cycle.

Top module: `fp_status_unit`

## Requirements
- R1: After reset the status word is zero, the rounding strobe is 4'b0001, flush is low and no trap is requested.
- R2: A write (`wr_en`) loads `wr_data` into the word at the next clock edge, and it overrides any operation or compare update in the same cycle. Such a cycle raises no trap. Status bits 10:0 change only through writes.
- R3: Word bits 10:9 drive the one-hot `round_sel`: 0 gives bit 0 (nearest-even), 1 gives bit 1 (toward zero), 2 gives bit 2 (toward plus infinity) and 3 gives bit 3 (toward minus infinity).
- R4: `flush_zero` follows word bit 5.
- R5: On `op_done` or `cmp_done`, the flags `op_flags` (bit 0 inexact, 1 underflow, 2 overflow, 3 divide-by-zero, 4 invalid) are ORed into word bits 31:27 at the same positions plus 27. Flags of zero leave the word unchanged, and an idle cycle leaves it unchanged.
- R6: `trap_req` is high for the one cycle after an update edge exactly when `op_flags` ANDed with word bits 4:0, as they stood before that edge, is nonzero.
- R7: The compare result is taken from `cmp_mask`: relation 0 (greater) picks bit 4, 1 (less) picks bit 3, 2 (equal) picks bit 2 and 3 (unordered) picks bit 1.
- R8: With `cmp_target` y from 1 to 11, the result is written into word bit 21-(y-1), and no other compare-area bit changes.
- R9: With `cmp_target` zero, bits 21:12 move down into 20:11, the old bit 26 moves into bit 21, and the result is written into bit 26.
- R10: With `cmp_target` from 12 to 15, no compare bit changes.
- R11: A compare applies its `op_flags` (R5, R6) in the same update as its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write value |
| op_done | input | 1 | Operation-complete pulse |
| op_flags | input | 5 | Exception flags of the completing operation or compare |
| cmp_done | input | 1 | Compare-complete pulse |
| cmp_rel | input | 2 | Relation code: 0 greater, 1 less, 2 equal, 3 unordered |
| cmp_mask | input | 5 | Predicate mask |
| cmp_target | input | 4 | Condition target: 0 selects the queue, 1..11 a direct bit |
| status | output | 32 | Current status word |
| round_sel | output | 4 | One-hot rounding mode |
| flush_zero | output | 1 | Flush-to-zero enable |
| trap_req | output | 1 | Trap request, one cycle |

## Verification
The flag path is swept over every pair of enable vector and flag vector. This tells OR accumulation apart from overwrite, and it checks that the trap follows only the overlap of new flags with enables. The compare path is swept over every relation, mask and target against a nonuniform background word. This separates the predicate selection, the direct bit index, the queue shift and the out-of-range targets. A run of queued compares without intervening writes shows that old results walk down the queue and drop out at its tail. Writes issued together with updates show the write priority, and a sweep of the control bits covers the rounding and flush decode.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
    localparam int WORD_W    = 32;
    localparam int FLAG_W    = 5;
    localparam int FLAG_LSB  = 27;
    localparam int CMP_BIT   = 26;
    localparam int QUEUE_TOP = 21;
    localparam int QUEUE_LEN = 10;
    localparam int TGT_W     = 4;
    localparam int RM_LSB    = 9;
    localparam int RM_W      = 2;
    localparam int FTZ_BIT   = 5;
    localparam int RM_NUM    = 1 << RM_W;

    typedef enum logic [1:0] {
        REL_GT = 2'd0,
        REL_LT = 2'd1,
        REL_EQ = 2'd2,
        REL_UN = 2'd3
    } rel_e;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              trap;
    } fpsr_state_t;
endpackage

// File: rtl/fpsr_flag_merge.sv
module fpsr_flag_merge
    import fpsr_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  logic              en_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic [WORD_W-1:0] word_o,
    output logic              trap_o
);
    localparam int PAD_W = WORD_W - FLAG_W;

    logic [WORD_W-1:0] flag_wide;

    always_comb begin
        flag_wide = {{PAD_W{1'b0}}, flags_i} << FLAG_LSB;
        word_o    = en_i ? (word_i | flag_wide) : word_i;
        trap_o    = en_i && (|(flags_i & word_i[FLAG_W-1:0]));
    end
endmodule

// File: rtl/fpsr_cmp_rec.sv
module fpsr_cmp_rec
    import fpsr_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  logic              en_i,
    input  rel_e              rel_i,
    input  logic [FLAG_W-1:0] mask_i,
    input  logic [TGT_W-1:0]  tgt_i,
    output logic [WORD_W-1:0] word_o
);
    localparam int Q_LSB   = QUEUE_TOP - QUEUE_LEN;
    localparam int MAX_TGT = QUEUE_LEN + 1;

    logic result;
    int   idx;

    always_comb begin
        unique case (rel_i)
            REL_GT:  result = mask_i[4];
            REL_LT:  result = mask_i[3];
            REL_EQ:  result = mask_i[2];
            default: result = mask_i[1];
        endcase
    end

    always_comb begin
        word_o = word_i;
        idx    = QUEUE_TOP - (int'(tgt_i) - 1);
        if (en_i) begin
            if (tgt_i == '0) begin
                for (int i = 0; i < QUEUE_LEN; i++) begin
                    word_o[Q_LSB + i] = word_i[Q_LSB + 1 + i];
                end
                word_o[QUEUE_TOP] = word_i[CMP_BIT];
                word_o[CMP_BIT]   = result;
            end else if (int'(tgt_i) <= MAX_TGT) begin
                word_o[idx] = result;
            end
        end
    end
endmodule

// File: rtl/fpsr_mode_dec.sv
module fpsr_mode_dec
    import fpsr_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output logic [RM_NUM-1:0] round_sel_o,
    output logic              flush_o
);
    logic [RM_W-1:0] rm;

    assign rm      = word_i[RM_LSB +: RM_W];
    assign flush_o = word_i[FTZ_BIT];

    for (genvar g = 0; g < RM_NUM; g++) begin : g_rm
        assign round_sel_o[g] = (rm == RM_W'(g));
    end
endmodule

// File: rtl/fp_status_unit.sv
module fp_status_unit
    import fpsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              op_done,
    input  logic [FLAG_W-1:0] op_flags,
    input  logic              cmp_done,
    input  logic [1:0]        cmp_rel,
    input  logic [FLAG_W-1:0] cmp_mask,
    input  logic [TGT_W-1:0]  cmp_target,
    output logic [WORD_W-1:0] status,
    output logic [RM_NUM-1:0] round_sel,
    output logic              flush_zero,
    output logic              trap_req
);
    fpsr_state_t       st_d, st_q;
    logic [WORD_W-1:0] flag_word, cmp_word;
    logic              flag_trap;

    fpsr_flag_merge u_flags (
        .word_i  (st_q.word),
        .en_i    (op_done | cmp_done),
        .flags_i (op_flags),
        .word_o  (flag_word),
        .trap_o  (flag_trap)
    );

    fpsr_cmp_rec u_cmp (
        .word_i (flag_word),
        .en_i   (cmp_done),
        .rel_i  (rel_e'(cmp_rel)),
        .mask_i (cmp_mask),
        .tgt_i  (cmp_target),
        .word_o (cmp_word)
    );

    fpsr_mode_dec u_mode (
        .word_i      (st_q.word),
        .round_sel_o (round_sel),
        .flush_o     (flush_zero)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.word = wr_data;
            st_d.trap = 1'b0;
        end else begin
            st_d.word = cmp_word;
            st_d.trap = flag_trap;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status   = st_q.word;
    assign trap_req = st_q.trap;
endmodule

// File: rtl/fp_status_unit_sva.sv
module fp_status_unit_sva
    import fpsr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [WORD_W-1:0] wr_data,
    input logic              op_done,
    input logic [FLAG_W-1:0] op_flags,
    input logic              cmp_done,
    input logic [1:0]        cmp_rel,
    input logic [FLAG_W-1:0] cmp_mask,
    input logic [TGT_W-1:0]  cmp_target,
    input logic [WORD_W-1:0] status,
    input logic [RM_NUM-1:0] round_sel,
    input logic              flush_zero,
    input logic              trap_req
);
    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> status == $past(wr_data)); // R2
    AST_CTRL_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> status[10:0] == $past(status[10:0])); // R2
    AST_ROUND_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(round_sel) == 1); // R3
    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (status[31:27] & $past(status[31:27])) == $past(status[31:27])); // R5
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !op_done && !cmp_done) |=> $stable(status)); // R5
    AST_TRAP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> ($past(op_done || cmp_done) && !$past(wr_en))); // R6
    AST_TARGET_SINGLE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_done && !wr_en && cmp_target != '0 && op_flags == '0)
        |=> $countones(status ^ $past(status)) <= 1); // R8
endmodule

bind fp_status_unit fp_status_unit_sva chk_i (.*);

// File: tb/fp_status_unit_tb_top.sv
module fp_status_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        op_done = 1'b0;
    logic [4:0]  op_flags = '0;
    logic        cmp_done = 1'b0;
    logic [1:0]  cmp_rel = '0;
    logic [4:0]  cmp_mask = '0;
    logic [3:0]  cmp_target = '0;
    logic [31:0] status;
    logic [3:0]  round_sel;
    logic        flush_zero;
    logic        trap_req;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    fp_status_unit dut_i (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%08h exp=%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_cmp(logic [31:0] w, logic [1:0] rel,
                                            logic [4:0] mask, logic [3:0] tgt);
        logic [31:0] n = w;
        logic        r = mask[4 - rel];
        if (tgt == 0) begin
            n[20:11] = w[21:12];
            n[21]    = w[26];
            n[26]    = r;
        end else if (tgt <= 11) begin
            n[22 - tgt] = r;
        end
        return n;
    endfunction

    task automatic do_write(logic [31:0] w);
        wr_en = 1'b1; wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_op(logic [4:0] fl);
        op_done = 1'b1; op_flags = fl;
        @(negedge clk);
        op_done = 1'b0; op_flags = '0;
    endtask

    task automatic do_cmp(logic [1:0] rel, logic [4:0] mask, logic [3:0] tgt, logic [4:0] fl);
        cmp_done = 1'b1; cmp_rel = rel; cmp_mask = mask; cmp_target = tgt; op_flags = fl;
        @(negedge clk);
        cmp_done = 1'b0; op_flags = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] base, exp_w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 status", status, 32'h0);
        check("R1 round_sel", {28'h0, round_sel}, 32'h1);
        check("R1 flush", {31'h0, flush_zero}, 32'h0);
        check("R1 trap", {31'h0, trap_req}, 32'h0);

        // R3 / R4 / R2: control decode
        for (int m = 0; m < 4; m++) begin
            for (int f = 0; f < 2; f++) begin
                base = (32'(m) << 9) | (32'(f) << 5) | 32'h0400_0000;
                do_write(base);
                check("R2 write", status, base);
                check("R3 round_sel", {28'h0, round_sel}, 32'h1 << m);
                check("R4 flush", {31'h0, flush_zero}, 32'(f));
            end
        end

        // R5 / R6: flag accumulation and trap, every enable x flag pair
        for (int en = 0; en < 32; en++) begin
            for (int fl = 0; fl < 32; fl++) begin
                base = 32'(en) | (32'((en * 7) & 31) << 27);
                do_write(base);
                do_op(5'(fl));
                check("R5 flags", status, base | (32'(fl) << 27));
                check("R6 trap", {31'h0, trap_req}, {31'h0, |(5'(en) & 5'(fl))});
                @(negedge clk);
                check("R6 trap pulse", {31'h0, trap_req}, 32'h0);
            end
        end

        // R2: write wins over same-cycle updates
        do_write(32'h0000_001F);
        wr_en = 1'b1; wr_data = 32'h1234_0600;
        op_done = 1'b1; cmp_done = 1'b1; op_flags = 5'h1F; cmp_mask = 5'h1F; cmp_target = 4'd0;
        @(negedge clk);
        wr_en = 1'b0; op_done = 1'b0; cmp_done = 1'b0; op_flags = '0;
        check("R2 priority", status, 32'h1234_0600);
        check("R2 no trap", {31'h0, trap_req}, 32'h0);

        // R7 / R8 / R9 / R10: every relation x mask x target
        for (int rel = 0; rel < 4; rel++) begin
            for (int mask = 0; mask < 32; mask++) begin
                for (int tgt = 0; tgt < 16; tgt++) begin
                    base = 32'hA5C3_5A3C ^ (32'(mask) << 12) ^ (32'(rel * 5 + tgt) << 21);
                    do_write(base);
                    do_cmp(2'(rel), 5'(mask), 4'(tgt), 5'h0);
                    exp_w = ref_cmp(base, 2'(rel), 5'(mask), 4'(tgt));
                    if (tgt == 0)       check("R9 queue push (R7)", status, exp_w);
                    else if (tgt <= 11) check("R8 target bit (R7)", status, exp_w);
                    else                check("R10 target ignored", status, exp_w);
                end
            end
        end

        // R9: successive queue pushes walk down and fall out of the tail
        base = 32'h0000_0000;
        do_write(base);
        exp_w = base;
        for (int k = 0; k < 14; k++) begin
            do_cmp(2'd2, (k % 3 == 0) ? 5'b00100 : 5'b11011, 4'd0, 5'h0);
            exp_w = ref_cmp(exp_w, 2'd2, (k % 3 == 0) ? 5'b00100 : 5'b11011, 4'd0);
            check("R9 queue walk", status, exp_w);
        end

        // R11: compare applies flags in the same update
        do_write(32'h0000_0004);
        do_cmp(2'd3, 5'b00010, 4'd3, 5'b00110);
        check("R11 cmp flags", status, (32'h0000_0004 | (32'h6 << 27)) | (32'h1 << 19));
        check("R11 cmp trap", {31'h0, trap_req}, 32'h1);
        do_cmp(2'd0, 5'b10000, 4'd0, 5'b01000);
        exp_w = ref_cmp((32'h0000_0004 | (32'hE << 27)) | (32'h1 << 19), 2'd0, 5'b10000, 4'd0);
        check("R11 cmp flags queue", status, exp_w);
        check("R11 no trap", {31'h0, trap_req}, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule